// File: doc/BRIEF.md
# Oscillator Alarm and Shutdown Supervisor

This block watches a bank of free-running oscillators that feed an entropy pool. Each oscillator can raise a one-cycle alarm pulse. The first accepted pulse only marks that oscillator as suspect. A second accepted pulse, arriving while the mark is still set, shuts the oscillator down: its enable bit is cleared and its bit in the stopped set is raised. Software sees the stopped set, clears it, and re-arms the bank by rewriting the enable mask.

Software reaches the block through a simple 32-bit register port: one write strobe, one address and combinational read data. Five registers are decoded: the shutdown threshold, the oscillator enable mask, a detune word, an alarm ignore mask and the stopped set. The detune word is only stored and driven out to the analogue side. A one-cycle shutdown-overflow pulse is produced for a status register elsewhere when a shutdown leaves more oscillators stopped than the threshold allows. A threshold of all ones makes every shutdown produce the pulse.

Top module: `osc_supervisor`

## Requirements
- R1: After reset the enable mask, alarm ignore mask, stopped set and detune word read 0, the threshold reads 0xFF and `shutdown_ovf` is 0.
- R2: The threshold sits at offset 0x1C in bits 7:0 (bits 31:8 read 0), the enable mask at 0x20, the detune word at 0x24 (also driven on `osc_detune`), the alarm ignore mask at 0x28 and the stopped set at 0x2C; bit k of the mask registers and of the stopped set refers to oscillator k; any other offset reads 0.
- R3: The first accepted alarm on an oscillator changes neither its enable bit nor its stopped bit.
- R4: A second accepted alarm on an oscillator while it is marked clears its enable bit and sets its stopped bit, visible at the next clock edge.
- R5: Stopped bits stay set until software writes offset 0x2C; such a write replaces the set with the written value (writing zero clears it), except that a shutdown in the same cycle is added on top.
- R6: Alarm pulses from an oscillator whose ignore-mask bit is 1 or whose enable bit is 0 are ignored: they neither mark nor stop it.
- R7: `shutdown_ovf` pulses for exactly one cycle, one cycle after a cycle with at least one shutdown, when the number of stopped oscillators after that cycle is greater than the threshold.
- R8: With the threshold at 0xFF, every shutdown produces the `shutdown_ovf` pulse.
- R9: A write to offset 0x20 loads the enable mask and clears every oscillator's mark; a shutdown in the same cycle still clears the affected enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| osc_alarm | input | 32 | Per-oscillator alarm pulses |
| osc_enable | output | 32 | Per-oscillator run enables |
| osc_detune | output | 32 | Stored detune word |
| shutdown_ovf | output | 1 | One-cycle shutdown overflow pulse |

## Verification
Two collisions matter: a software write to the enable mask landing in the same cycle as an oscillator's second alarm, and a write clearing the stopped set in the same cycle as a fresh shutdown. The bench arms an oscillator, then drives the write strobe and that oscillator's alarm on the same clock edge. It judges the result by reading back that the enable bit stays cleared and that the stopped set holds exactly the new bit, as R9 and R5 demand.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
    localparam int ADDR_W = 8;
    localparam int THR_W  = 8;
    localparam logic [ADDR_W-1:0] OFS_THR  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STOP = 8'h2C;
    localparam logic [THR_W-1:0]  THR_ANY  = '1;
endpackage

// File: rtl/osc_alarm_lane.sv
module osc_alarm_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_i,
    input  logic enable_i,
    input  logic mask_i,
    input  logic rearm_i,
    output logic stop_o
);
    logic armed_q, armed_d, valid;

    always_comb begin
        valid   = alarm_i & enable_i & ~mask_i;
        stop_o  = valid & armed_q;
        armed_d = armed_q;
        if (rearm_i)    armed_d = 1'b0;
        else if (valid) armed_d = ~armed_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R4: a shutdown consumes the mark
    assert_stop_clears_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !armed_q);
    // R6: an ignored pulse leaves the mark untouched
    assert_masked_no_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_i && (mask_i || !enable_i) && !rearm_i) |=> $stable(armed_q));
endmodule

// File: rtl/osc_stop_count.sv
module osc_stop_count #(
    parameter int N     = 32,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec_i,
    output logic [CNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) count_o = count_o + CNT_W'(vec_i[i]);
    end
endmodule

// File: rtl/osc_supervisor.sv
module osc_supervisor
    import osc_sup_pkg::*;
#(
    parameter int NUM_OSC = 32,
    parameter int DATA_W  = 32,
    localparam int CNT_W  = $clog2(NUM_OSC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_OSC-1:0]  osc_alarm,
    output logic [NUM_OSC-1:0]  osc_enable,
    output logic [DATA_W-1:0]   osc_detune,
    output logic                shutdown_ovf
);
    typedef struct packed {
        logic [NUM_OSC-1:0] en;
        logic [NUM_OSC-1:0] mask;
        logic [NUM_OSC-1:0] stop;
        logic [DATA_W-1:0]  det;
        logic [THR_W-1:0]   thr;
        logic               ovf;
    } state_t;

    state_t st_q, st_d;
    logic [NUM_OSC-1:0] stop_ev;
    logic [CNT_W-1:0]   stop_cnt_d;
    logic wr_thr, wr_en, wr_det, wr_mask, wr_stop;

    assign wr_thr  = bus_wr && (bus_addr == OFS_THR);
    assign wr_en   = bus_wr && (bus_addr == OFS_EN);
    assign wr_det  = bus_wr && (bus_addr == OFS_DET);
    assign wr_mask = bus_wr && (bus_addr == OFS_MASK);
    assign wr_stop = bus_wr && (bus_addr == OFS_STOP);

    for (genvar k = 0; k < NUM_OSC; k++) begin : g_lane
        osc_alarm_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .alarm_i  (osc_alarm[k]),
            .enable_i (st_q.en[k]),
            .mask_i   (st_q.mask[k]),
            .rearm_i  (wr_en),
            .stop_o   (stop_ev[k])
        );
    end

    osc_stop_count #(.N(NUM_OSC)) u_count (
        .vec_i   (st_d.stop),
        .count_o (stop_cnt_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.en   = (wr_en   ? bus_wdata[NUM_OSC-1:0] : st_q.en) & ~stop_ev;
        st_d.stop = (wr_stop ? bus_wdata[NUM_OSC-1:0] : st_q.stop) | stop_ev;
        if (wr_mask) st_d.mask = bus_wdata[NUM_OSC-1:0];
        if (wr_det)  st_d.det  = bus_wdata;
        if (wr_thr)  st_d.thr  = bus_wdata[THR_W-1:0];
        st_d.ovf = (|stop_ev) &&
                   ((st_q.thr == THR_ANY) || (32'(stop_cnt_d) > 32'(st_q.thr)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.mask <= '0;
            st_q.stop <= '0;
            st_q.det  <= '0;
            st_q.thr  <= THR_ANY;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_THR:  bus_rdata[THR_W-1:0]   = st_q.thr;
            OFS_EN:   bus_rdata[NUM_OSC-1:0] = st_q.en;
            OFS_DET:  bus_rdata              = st_q.det;
            OFS_MASK: bus_rdata[NUM_OSC-1:0] = st_q.mask;
            OFS_STOP: bus_rdata[NUM_OSC-1:0] = st_q.stop;
            default:  bus_rdata              = '0;
        endcase
    end

    assign osc_enable   = st_q.en;
    assign osc_detune   = st_q.det;
    assign shutdown_ovf = st_q.ovf;

    // R4: shut-down oscillators are disabled and recorded
    assert_shutdown_applied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_ev) |=> (((st_q.en & $past(stop_ev)) == '0) &&
                        ((st_q.stop & $past(stop_ev)) == $past(stop_ev))));
    // R5: stopped bits never fall without a write to the stopped set
    assert_stop_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stop |=> ((st_q.stop & $past(st_q.stop)) == $past(st_q.stop)));
    // R7: overflow only follows a shutdown cycle
    assert_ovf_after_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_ovf |-> $past(|stop_ev));
    // R8: all-ones threshold reports every shutdown
    assert_ovf_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stop_ev) && (st_q.thr == THR_ANY)) |=> shutdown_ovf);
endmodule

// File: tb/tb_osc_supervisor.sv
module tb_osc_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] osc_alarm = '0;
    logic [31:0] osc_enable;
    logic [31:0] osc_detune;
    logic        shutdown_ovf;

    int checks = 0;
    int fails  = 0;
    logic last_ovf;
    logic [31:0] rd;

    osc_supervisor dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_alarm(osc_alarm),
        .osc_enable(osc_enable), .osc_detune(osc_detune), .shutdown_ovf(shutdown_ovf)
    );

    always #2 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1 rd = bus_rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        osc_alarm[k] = 1'b1;
        @(negedge clk);
        osc_alarm = '0;
        last_ovf = shutdown_ovf;
    endtask

    task automatic rearm_all();
        wr(8'h2C, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        check({31'b0, shutdown_ovf}, 32'h0, "R1 ovf");
        rd_reg(8'h20); check(rd, 32'h0, "R1 enable");
        rd_reg(8'h28); check(rd, 32'h0, "R1 mask");
        rd_reg(8'h2C); check(rd, 32'h0, "R1 stop");
        rd_reg(8'h24); check(rd, 32'h0, "R1 detune");
        rd_reg(8'h1C); check(rd, 32'hFF, "R1 threshold");
    endtask

    task automatic t_regs();
        wr(8'h1C, 32'hABCD_1234); rd_reg(8'h1C); check(rd, 32'h34, "R2 threshold field");
        wr(8'h1C, 32'hFF);
        wr(8'h24, 32'h5A5A_0F0F); rd_reg(8'h24); check(rd, 32'h5A5A_0F0F, "R2 detune");
        check(osc_detune, 32'h5A5A_0F0F, "R2 detune pin");
        wr(8'h28, 32'h0000_8001); rd_reg(8'h28); check(rd, 32'h0000_8001, "R2 mask");
        wr(8'h28, 32'h0);
        rd_reg(8'h40); check(rd, 32'h0, "R2 unmapped");
    endtask

    task automatic t_shutdown();
        rearm_all();
        pulse(3);
        check(osc_enable, 32'hFFFF_FFFF, "R3 enable after first alarm");
        rd_reg(8'h2C); check(rd, 32'h0, "R3 stop after first alarm");
        pulse(3);
        check({31'b0, last_ovf}, 32'h1, "R8 ovf on any shutdown");
        check(osc_enable, 32'hFFFF_FFF7, "R4 enable bit 3 cleared");
        rd_reg(8'h2C); check(rd, 32'h8, "R4 stop bit 3 set");
        check({31'b0, shutdown_ovf}, 32'h0, "R7 ovf lasts one cycle");
        pulse(3);
        rd_reg(8'h2C); check(rd, 32'h8, "R5 stop sticky");
    endtask

    task automatic t_ignore();
        rearm_all();
        wr(8'h28, 32'h20);
        pulse(5); pulse(5);
        check(osc_enable, 32'hFFFF_FFFF, "R6 masked oscillator keeps enable");
        rd_reg(8'h2C); check(rd, 32'h0, "R6 masked oscillator not stopped");
        wr(8'h28, 32'h0);
        wr(8'h20, 32'hFFFF_FFBF);
        pulse(6); pulse(6);
        rd_reg(8'h2C); check(rd, 32'h0, "R6 disabled oscillator not stopped");
        wr(8'h20, 32'hFFFF_FFFF);
        pulse(6);
        rd_reg(8'h2C); check(rd, 32'h0, "R6 disabled pulses left no mark");
    endtask

    task automatic t_threshold();
        rearm_all();
        wr(8'h1C, 32'h1);
        pulse(0); pulse(0);
        check({31'b0, last_ovf}, 32'h0, "R7 count 1 not above threshold 1");
        pulse(1); pulse(1);
        check({31'b0, last_ovf}, 32'h1, "R7 count 2 above threshold 1");
        rd_reg(8'h2C); check(rd, 32'h3, "R7 stop set");
        wr(8'h1C, 32'hFF);
    endtask

    task automatic t_rearm();
        rearm_all();
        pulse(7);
        wr(8'h20, 32'hFFFF_FFFF);
        pulse(7);
        check(osc_enable, 32'hFFFF_FFFF, "R9 enable write clears mark");
        rd_reg(8'h2C); check(rd, 32'h0, "R9 no stop after re-arm");
    endtask

    task automatic t_collide();
        rearm_all();
        pulse(9);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'hFFFF_FFFF; osc_alarm[9] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; osc_alarm = '0;
        check(osc_enable, 32'hFFFF_FDFF, "R9 shutdown overrides enable write");
        rd_reg(8'h2C); check(rd, 32'h200, "R4 stop bit 9 on collision");
        pulse(10);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h0; osc_alarm[10] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; osc_alarm = '0;
        rd_reg(8'h2C); check(rd, 32'h400, "R5 clear write keeps new shutdown");
        wr(8'h2C, 32'h0);
        rd_reg(8'h2C); check(rd, 32'h0, "R5 zero write clears");
    endtask

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_shutdown();
        t_ignore();
        t_threshold();
        t_rearm();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule